// File: doc/BRIEF.md
# Configurable SPI Master Shift Engine

This block is the serial engine of an SPI master. A single start strobe launches one transfer of one character. Each transfer takes a mode word, a 16-bit transmit character and a start strobe. The mode word holds a length code, a clock-divide code, an idle-level select and a phase select. The engine lowers the select line, drives the clock and shifts the character out on MOSI most significant bit first. At the same time it shifts in MISO. At the end it raises select and reports the received character with a one-cycle done pulse.

The character length is the length code plus one and runs from 4 to 16 bits. Codes 0 to 2 are not legal configurations. The serial clock runs at the base clock divided by four times one more than the divide code, so the ratio lies between 4 and 64. The clock has a 50% duty cycle. The phase select decides where the clock starts toggling. In one setting it starts half-way through the first bit time, after the data is already set up. In the other it toggles at the start of each bit time. The mode word and the transmit character are captured when a transfer is accepted, so the inputs may change while the transfer runs.

Top module: `spi_eng_master`

## Requirements
- R1: The character length is `len_code` + 1 bits. Codes 3 (4 bits) to 15 (16 bits) are the legal range. Codes below 3 are not a supported configuration.
- R2: One half bit time lasts 2×(`div_code`+1) base-clock cycles, so a full serial-clock period is 4×(`div_code`+1) cycles with equal high and low time. `sclk` changes level only at half-bit boundaries.
- R3: `sclk` rests at the level of `clk_idle_hi` (0 = low, 1 = high). While no transfer runs, `sclk` follows that input with one cycle of delay. During a transfer and in its done cycle, `sclk` rests at the level captured at the start.
- R4: With `clk_lead` = 0, the first bit is on MOSI from the first cycle of the transfer. The first clock edge comes one half bit later. Counting clock edges from 1, MISO is sampled on edges 1, 3, 5, … and MOSI advances on edges 2, 4, … up to edge 2N−2.
- R5: With `clk_lead` = 1, the clock toggles at the start of every bit time. MOSI advances on edges 3, 5, … up to edge 2N−1, and MISO is sampled on edges 2, 4, … up to edge 2N.
- R6: The transmit bits are bits N−1 down to 0 of `tx_data`, sent from the most significant of them. Upper bits of `tx_data` have no effect.
- R7: `sel_n` goes low in the cycle after a start is accepted, and the first clock edge follows one half bit later. After the last of the 2N edges, one more half bit passes. Then `sel_n` returns high and `done` is high for exactly that one cycle.
- R8: `rx_data` holds the received bits right-justified. The first bit received lands in bit N−1, and bits above N−1 are zero. It updates in the done cycle and holds its value until the next done.
- R9: A `start` while `busy` is high has no effect. The mode word and the transmit character are taken only in the accepting cycle, and later changes to them do not affect the running transfer.
- R10: `mosi` is low whenever `sel_n` is high.
- R11: After reset, `sel_n` = 1, `sclk` = 0, `mosi` = 0, `busy` = 0, `done` = 0 and `rx_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Transfer request, taken when idle |
| len_code | input | 4 | Character length minus one |
| div_code | input | 4 | Clock-divide code, ratio 4×(code+1) |
| clk_idle_hi | input | 1 | Serial-clock idle level |
| clk_lead | input | 1 | 1: clock toggles at the start of each bit; 0: mid-bit |
| tx_data | input | 16 | Transmit character, low N bits used |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| sel_n | output | 1 | Active-low slave select |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 16 | Received character, right-justified |

## Verification
The checker assumes that `len_code` is at least 3 whenever a start is taken. Its check on the zeroed upper bits of `rx_data` depends on that. The stimulus uses only legal length codes, including both the shortest and the longest. It mixes every phase and idle-level setting with slow and fast divide codes. MISO changes on every cycle, so a sample taken on the wrong edge shows up in the received character. One transfer receives a second start mid-way, together with a changed mode word and transmit character. That covers the ignore-while-busy rule without leaving the legal range.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    // Per-cycle strobes from the edge controller to the shifter and FSM.
    typedef struct packed {
        logic launch;   // advance MOSI to the next bit
        logic sample;   // capture MISO
        logic finish;   // final half bit elapsed
    } edge_evt_t;

    localparam int MIN_BITS = 4;

    // Number of bits in a character for a given length code.
    function automatic int char_bits(input int code);
        return (code < MIN_BITS - 1) ? MIN_BITS : code + 1;
    endfunction

    // Base-clock cycles in one half bit time minus one.
    function automatic int half_limit(input int div);
        return 2 * div + 1;
    endfunction

endpackage

// File: rtl/spi_eng_prescale.sv
module spi_eng_prescale #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    import spi_eng_pkg::*;

    localparam int PRE_W = DIV_W + 1;

    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] lim;

    assign lim  = PRE_W'(half_limit(int'(div)));
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (run) begin
            if (cnt == lim) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_eng_edge_ctrl.sv
module spi_eng_edge_ctrl #(
    parameter int DATA_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic                       run,
    input  logic                       tick,
    input  logic [$clog2(DATA_W)-1:0]  len_code,
    input  logic                       lead,
    input  logic                       idle_hi,
    input  logic                       idle_live,
    output logic                       sclk,
    output spi_eng_pkg::edge_evt_t     evt
);
    import spi_eng_pkg::*;

    localparam int CNT_W = $clog2(2 * DATA_W + 1);

    logic [CNT_W-1:0] tog_cnt;
    logic [CNT_W-1:0] next_k;
    logic [CNT_W-1:0] last_k;
    logic             in_clock;
    logic             step;

    assign last_k   = CNT_W'(2 * char_bits(int'(len_code)));
    assign next_k   = tog_cnt + 1'b1;
    assign in_clock = tog_cnt < last_k;
    assign step     = run && tick;

    always_comb begin
        evt.sample = 1'b0;
        evt.launch = 1'b0;
        evt.finish = step && !in_clock;
        if (step && in_clock) begin
            if (lead) begin
                evt.sample = !next_k[0];
                evt.launch = next_k[0] && (next_k >= CNT_W'(3));
            end else begin
                evt.sample = next_k[0];
                evt.launch = !next_k[0] && (next_k < last_k);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_cnt <= '0;
            sclk    <= 1'b0;
        end else if (load) begin
            tog_cnt <= '0;
            sclk    <= idle_live;
        end else if (run) begin
            if (step && in_clock) begin
                tog_cnt <= next_k;
                sclk    <= ~sclk;
            end else if (evt.finish) begin
                sclk    <= idle_hi;
            end
        end else begin
            sclk <= idle_live;
        end
    end

endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter #(
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic [DATA_W-1:0]         tx,
    input  logic [$clog2(DATA_W)-1:0] len_code,
    input  spi_eng_pkg::edge_evt_t    evt,
    input  logic                      miso,
    output logic                      mosi_bit,
    output logic [DATA_W-1:0]         rx_data
);
    import spi_eng_pkg::*;

    logic [DATA_W-1:0] tx_sr;
    logic [DATA_W-1:0] rx_sr;
    int                pad;

    // Left-align the character so its first bit sits in the top position.
    assign pad      = DATA_W - char_bits(int'(len_code));
    assign mosi_bit = tx_sr[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr   <= '0;
            rx_sr   <= '0;
            rx_data <= '0;
        end else begin
            if (load) begin
                tx_sr <= tx << pad;
                rx_sr <= '0;
            end else begin
                if (evt.launch) begin
                    tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
                end
                if (evt.sample) begin
                    rx_sr <= {rx_sr[DATA_W-2:0], miso};
                end
            end
            if (evt.finish) begin
                rx_data <= rx_sr;
            end
        end
    end

endmodule

// File: rtl/spi_eng_master.sv
module spi_eng_master #(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [$clog2(DATA_W)-1:0] len_code,
    input  logic [DIV_W-1:0]          div_code,
    input  logic                      clk_idle_hi,
    input  logic                      clk_lead,
    input  logic [DATA_W-1:0]         tx_data,
    input  logic                      miso,
    output logic                      sclk,
    output logic                      mosi,
    output logic                      sel_n,
    output logic                      busy,
    output logic                      done,
    output logic [DATA_W-1:0]         rx_data
);
    import spi_eng_pkg::*;

    localparam int CODE_W = $clog2(DATA_W);

    run_state_t        state;
    logic [CODE_W-1:0] len_q;
    logic [DIV_W-1:0]  div_q;
    logic              idle_q;
    logic              lead_q;
    logic              accept;
    logic              tick;
    logic              mosi_bit;
    edge_evt_t         evt;

    assign busy   = (state == ST_RUN);
    assign accept = start && !busy;
    assign sel_n  = !busy;
    assign mosi   = busy && mosi_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            len_q  <= '0;
            div_q  <= '0;
            idle_q <= 1'b0;
            lead_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                state  <= ST_RUN;
                len_q  <= len_code;
                div_q  <= div_code;
                idle_q <= clk_idle_hi;
                lead_q <= clk_lead;
            end else if (evt.finish) begin
                state <= ST_IDLE;
                done  <= 1'b1;
            end
        end
    end

    spi_eng_prescale #(
        .DIV_W(DIV_W)
    ) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .run     (busy),
        .div     (div_q),
        .tick    (tick)
    );

    spi_eng_edge_ctrl #(
        .DATA_W(DATA_W)
    ) u_edge (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .run       (busy),
        .tick      (tick),
        .len_code  (len_q),
        .lead      (lead_q),
        .idle_hi   (idle_q),
        .idle_live (clk_idle_hi),
        .sclk      (sclk),
        .evt       (evt)
    );

    spi_eng_shifter #(
        .DATA_W(DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .tx       (tx_data),
        .len_code (len_code),
        .evt      (evt),
        .miso     (miso),
        .mosi_bit (mosi_bit),
        .rx_data  (rx_data)
    );

endmodule

// File: rtl/spi_eng_master_chk.sv
module spi_eng_master_chk #(
    parameter int DATA_W = 16
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      start,
    input logic                      busy,
    input logic                      sel_n,
    input logic                      sclk,
    input logic                      mosi,
    input logic                      done,
    input logic [DATA_W-1:0]         rx_data,
    input logic [$clog2(DATA_W)-1:0] len_code,
    input logic [$clog2(DATA_W)-1:0] len_q,
    input logic                      idle_q,
    input logic                      tick
);

    assert_len_legal_R1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |-> (len_code >= 3));

    assert_toggle_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && $past(!sel_n) && (sclk != $past(sclk))) |-> $past(tick));

    assert_idle_level_at_end_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (sclk == idle_q));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_with_release_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (sel_n && $past(!sel_n)));

    assert_rx_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> ((rx_data >> (int'(len_q) + 1)) == '0));

    assert_ignore_start_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(len_q));

    assert_mosi_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        sel_n |-> !mosi);

endmodule

bind spi_eng_master spi_eng_master_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .sel_n    (sel_n),
    .sclk     (sclk),
    .mosi     (mosi),
    .done     (done),
    .rx_data  (rx_data),
    .len_code (len_code),
    .len_q    (len_q),
    .idle_q   (idle_q),
    .tick     (tick)
);

// File: tb/spi_eng_master_tb.sv
module spi_eng_master_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [3:0]  len_code;
    logic [3:0]  div_code;
    logic        clk_idle_hi;
    logic        clk_lead;
    logic [15:0] tx_data;
    logic        miso;
    logic        sclk;
    logic        mosi;
    logic        sel_n;
    logic        busy;
    logic        done;
    logic [15:0] rx_data;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [15:0] prev_rx = '0;

    always #5 clk = ~clk;

    spi_eng_master u_dut (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .len_code    (len_code),
        .div_code    (div_code),
        .clk_idle_hi (clk_idle_hi),
        .clk_lead    (clk_lead),
        .tx_data     (tx_data),
        .miso        (miso),
        .sclk        (sclk),
        .mosi        (mosi),
        .sel_n       (sel_n),
        .busy        (busy),
        .done        (done),
        .rx_data     (rx_data)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", what, $time, act, exp);
        end
    endtask

    // Reference model: the expected outputs depend only on the cycle count since
    // the transfer was accepted and on the arguments, compared on every cycle.
    task automatic run_xfer(input int len, input int div, input bit idle, input bit lead,
                            input logic [15:0] tx, input bit poke);
        int          n;
        int          h;
        int          endc;
        logic [15:0] exp_rx;
        bit          hist[0:2047];
        n    = len + 1;             // R1: length is code plus one
        h    = 2 * (div + 1);       // R2: half bit time in base cycles
        endc = (2 * n + 1) * h;
        len_code    = 4'(len);
        div_code    = 4'(div);
        clk_idle_hi = idle;
        clk_lead    = lead;
        tx_data     = tx;
        start       = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c <= endc; c++) begin
            if (c > 0) @(negedge clk);
            if (c < endc) begin
                int hh;
                int tg;
                int b;
                hh = c / h;
                tg = (hh < 2 * n) ? hh : 2 * n;
                if (!lead) b = hh / 2;                        // R4
                else       b = (hh <= 1) ? 0 : (hh - 1) / 2;  // R5
                if (b > n - 1) b = n - 1;
                chk(16'(sel_n), 16'd0, "R7 sel_n low during transfer");
                chk(16'(sclk), 16'(idle ^ tg[0]), lead ? "R5 sclk" : "R4 sclk");
                chk(16'(mosi), 16'(tx[n-1-b]), "R6 mosi bit");
                chk(16'(done), 16'd0, "R7 done quiet");
                chk(16'(busy), 16'd1, "R9 busy");
                chk(rx_data, prev_rx, "R8 rx hold");
                if (poke && c == 2 * h) begin
                    // R9: second request with a different mode and character
                    start       = 1'b1;
                    len_code    = 4'd5;
                    div_code    = 4'(div ^ 1);
                    clk_idle_hi = !idle;
                    clk_lead    = !lead;
                    tx_data     = ~tx;
                end
                if (poke && c == 2 * h + 1) start = 1'b0;
                miso    = 1'($urandom_range(0, 1));
                hist[c] = miso;
            end else begin
                exp_rx = '0;
                for (int j = 0; j < n; j++) begin
                    int k;
                    k = lead ? (2 * j + 2) : (2 * j + 1);
                    exp_rx[n-1-j] = hist[k * h - 1];
                end
                chk(16'(done), 16'd1, "R7 done pulse");
                chk(16'(sel_n), 16'd1, "R7 sel_n release");
                chk(16'(sclk), 16'(idle), "R3 sclk idle at end");
                chk(16'(mosi), 16'd0, "R10 mosi low when deselected");
                chk(16'(busy), 16'd0, "R9 busy clear");
                chk(rx_data, exp_rx, "R8 rx right-justified");
                prev_rx = exp_rx;
            end
        end
    endtask

    initial begin
        rst         = 1'b1;
        start       = 1'b0;
        len_code    = 4'd7;
        div_code    = 4'd0;
        clk_idle_hi = 1'b0;
        clk_lead    = 1'b0;
        tx_data     = '0;
        miso        = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk(16'(sel_n), 16'd1, "R11 sel_n");
        chk(16'(sclk), 16'd0, "R11 sclk");
        chk(16'(mosi), 16'd0, "R11 mosi");
        chk(16'(busy), 16'd0, "R11 busy");
        chk(16'(done), 16'd0, "R11 done");
        chk(rx_data, 16'd0, "R11 rx_data");
        // R3: idle level follows the select input while no transfer runs
        clk_idle_hi = 1'b1;
        @(negedge clk);
        chk(16'(sclk), 16'd1, "R3 idle high");
        chk(16'(mosi), 16'd0, "R10 mosi idle");

        run_xfer(7, 0, 1'b0, 1'b0, 16'hA5C3, 1'b0);   // R4 8-bit, fastest
        run_xfer(15, 3, 1'b1, 1'b1, 16'h8001, 1'b0);  // R5 16-bit
        run_xfer(3, 1, 1'b0, 1'b1, 16'hFFF6, 1'b0);   // R1 4-bit, R6 upper bits unused
        run_xfer(11, 15, 1'b1, 1'b0, 16'h0ABC, 1'b0); // R2 slowest divide
        run_xfer(8, 2, 1'b1, 1'b1, 16'h1234, 1'b1);   // R9 start while busy
        run_xfer(15, 0, 1'b0, 1'b0, 16'hFFFF, 1'b0);  // R7 back-to-back after done

        @(negedge clk);
        chk(16'(done), 16'd0, "R7 done single cycle");
        chk(16'(mosi), 16'd0, "R10 mosi after transfer");
        chk(rx_data, prev_rx, "R8 rx hold after done");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule